// File: doc/BRIEF.md
# Dual-Clock-Mode Converter Serial Readout Port

This block sits between a 16-bit conversion core and a single serial data pin. It keeps the most recent conversion result and sends it out bit by bit, most significant bit first. A mode input picks one of two readout schemes.

In self-clocked mode, a conversion start makes the block send the result word it already holds, which is the previous conversion's. It generates exactly sixteen data clock pulses from the system clock through a parameterised divider. Between frames the data line holds a marker level taken from the tag input. In host-clocked mode, a host drives the data clock. A read trigger produces a one-clock-wide frame marker, followed by the sixteen data bits. After the data bits, the tag input is passed through with a sixteen-clock delay, so that several ports can be daisy-chained. A format input selects straight binary or two's complement coding.

The read/convert, chip-select, host clock and tag inputs are asynchronous to the system clock. Each passes through a two-stage synchroniser. The mode and format inputs are static straps and are sampled directly. A new result strobed in while a frame is being sent waits in a pending register until that frame is finished.

Top module: `adc_sio_port`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `dclk_o`, `sdata_o` and `sync_o` are all low.
- R2: With `mode_ext` low and `cs_n` low, each falling edge of `rc` produces exactly 16 rising edges on `dclk_o`. `dclk_o` then stays low until the next conversion start.
- R3: In self-clocked mode, the frame carries the result word held before the start, MSB first, one bit per pulse. `sdata_o` never changes while `dclk_o` is high, so each bit can be taken at the rising edge of `dclk_o`.
- R4: In self-clocked mode, after the sixteenth pulse `sdata_o` holds the level `tag` had at the conversion start, even if `tag` changes later.
- R5: With `fmt_straight` high, the word is sent unchanged (straight binary, midscale 0x8000). With it low, bit 15 is inverted (two's complement), so 0x8000 is sent as 0x0000 and 0x0001 as 0x8001.
- R6: With `mode_ext` high, a read trigger arms the port. The trigger is a rising edge of `rc` while `cs_n` is low, or a falling edge of `cs_n` while `rc` is high. `sync_o` is then high during the high phase of the first following `ext_dclk` pulse and low at every other sampled pulse. `sync_o` is never high when `mode_ext` is low.
- R7: In host-clocked mode, numbering the `ext_dclk` rising edges after a trigger from 1, the value of `sdata_o` at edge n is word bit 17-n, for n = 2 to 17.
- R8: From edge 18 on, `sdata_o` at edge n equals the `tag` value sampled at edge n-16, for as long as `cs_n` stays low and `rc` stays high. When that condition ends, the frame ends and `sdata_o` and `sync_o` go low.
- R9: A result strobed on `load` while a frame is in progress, or in the same cycle that a frame starts, is not sent in that frame. It is sent by the next frame.
- R10: Consecutive rising edges of `dclk_o` within a frame are exactly 2*HALF_CYC system clocks apart.
- R11: In self-clocked mode, a falling edge of `rc` while `cs_n` is high starts no frame, and `ext_dclk` activity produces no `sync_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_ext | input | 1 | 1: host-clocked readout, 0: self-clocked readout (static) |
| fmt_straight | input | 1 | 1: straight binary, 0: two's complement (static) |
| rc | input | 1 | Read/convert control line |
| cs_n | input | 1 | Active-low select |
| ext_dclk | input | 1 | Host-supplied data clock |
| tag | input | 1 | Daisy-chain / idle marker input |
| load | input | 1 | One-cycle strobe: `result` holds a new conversion |
| result | input | WIDTH | Conversion result, straight binary |
| dclk_o | output | 1 | Generated data clock (low in host-clocked mode) |
| sdata_o | output | 1 | Serial data |
| sync_o | output | 1 | Frame marker in host-clocked mode |

## Verification
Two events can fall in the same system clock: a conversion start, and the strobe that delivers a new result. The bench times `load` to land in the exact cycle in which the synchronised `rc` edge starts a frame. It then checks that this frame carries the older word and that the following frame carries the new one. A strobe in the middle of a frame is judged the same way, through a scoreboard that pops one expected bit at each generated clock rising edge.

// File: rtl/adc_sio_pkg.sv
package adc_sio_pkg;

  // Self-clocked engine phases.
  typedef enum logic [1:0] {
    I_IDLE,
    I_LEAD,
    I_RUN
  } int_state_t;

  // Host-clocked engine phases.
  typedef enum logic [2:0] {
    E_IDLE,
    E_ARM,
    E_SYNC,
    E_DATA,
    E_TAG
  } ext_state_t;

endpackage

// File: rtl/adc_sio_sync.sv
module adc_sio_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/adc_sio_intclk.sv
module adc_sio_intclk
  import adc_sio_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int HALF_CYC = 22,
  parameter int LEAD_CYC = 45
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] word,
  input  logic             tag_lvl,
  output logic             dclk,
  output logic             sdata,
  output logic             busy
);

  localparam int CNT_MAX = (HALF_CYC > LEAD_CYC) ? HALF_CYC : LEAD_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int BW      = $clog2(WIDTH);

  int_state_t       st;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bitn;
  logic [WIDTH-1:0] shreg;
  logic             idle_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= I_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      shreg    <= '0;
      idle_lvl <= 1'b0;
      dclk     <= 1'b0;
      sdata    <= 1'b0;
    end else begin
      case (st)
        I_IDLE: begin
          if (start) begin
            // MSB is presented at once so it is settled before the first rise
            shreg    <= {word[WIDTH-2:0], word[WIDTH-1]};
            sdata    <= word[WIDTH-1];
            idle_lvl <= tag_lvl;
            cnt      <= CW'(LEAD_CYC - 1);
            st       <= I_LEAD;
          end
        end
        I_LEAD: begin
          if (cnt == '0) begin
            dclk <= 1'b1;
            cnt  <= CW'(HALF_CYC - 1);
            bitn <= '0;
            st   <= I_RUN;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        I_RUN: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            cnt <= CW'(HALF_CYC - 1);
            if (dclk) begin
              dclk <= 1'b0;
              if (bitn == BW'(WIDTH - 1)) begin
                sdata <= idle_lvl;
                st    <= I_IDLE;
              end else begin
                // data moves only on the falling edge
                sdata <= shreg[WIDTH-1];
                shreg <= {shreg[WIDTH-2:0], shreg[WIDTH-1]};
                bitn  <= bitn + 1'b1;
              end
            end else begin
              dclk <= 1'b1;
            end
          end
        end
        default: st <= I_IDLE;
      endcase
    end
  end

  assign busy = (st != I_IDLE);

endmodule

// File: rtl/adc_sio_extclk.sv
module adc_sio_extclk
  import adc_sio_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic             keep,
  input  logic             rise,
  input  logic             fall,
  input  logic             tag_bit,
  input  logic [WIDTH-1:0] word,
  output logic             sdata,
  output logic             sync,
  output logic             busy
);

  localparam int BW = $clog2(WIDTH);

  ext_state_t       st;
  logic [BW-1:0]    bitn;
  logic [WIDTH-1:0] shreg;
  logic [WIDTH-1:0] tag_pipe;

  // Tag delay line: one stage per host clock rising edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      tag_pipe <= '0;
    end else if (rise) begin
      tag_pipe <= {tag_pipe[WIDTH-2:0], tag_bit};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= E_IDLE;
      bitn  <= '0;
      shreg <= '0;
      sdata <= 1'b0;
      sync  <= 1'b0;
    end else if (!keep && (st != E_IDLE)) begin
      st    <= E_IDLE;
      sdata <= 1'b0;
      sync  <= 1'b0;
    end else begin
      case (st)
        E_IDLE: begin
          if (trig) begin
            shreg <= word;
            st    <= E_ARM;
          end
        end
        E_ARM: begin
          if (rise) begin
            sync <= 1'b1;
            st   <= E_SYNC;
          end
        end
        E_SYNC: begin
          if (fall) begin
            sync  <= 1'b0;
            sdata <= shreg[WIDTH-1];
            shreg <= {shreg[WIDTH-2:0], shreg[WIDTH-1]};
            bitn  <= '0;
            st    <= E_DATA;
          end
        end
        E_DATA: begin
          if (fall) begin
            if (bitn == BW'(WIDTH - 1)) begin
              sdata <= tag_pipe[WIDTH-1];
              st    <= E_TAG;
            end else begin
              sdata <= shreg[WIDTH-1];
              shreg <= {shreg[WIDTH-2:0], shreg[WIDTH-1]};
              bitn  <= bitn + 1'b1;
            end
          end
        end
        E_TAG: begin
          if (fall) sdata <= tag_pipe[WIDTH-1];
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  assign busy = (st == E_ARM) || (st == E_SYNC) || (st == E_DATA);

endmodule

// File: rtl/adc_sio_port.sv
module adc_sio_port #(
  parameter int WIDTH    = 16,
  parameter int HALF_CYC = 22,
  parameter int LEAD_CYC = 45,
  parameter int SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_ext,
  input  logic             fmt_straight,
  input  logic             rc,
  input  logic             cs_n,
  input  logic             ext_dclk,
  input  logic             tag,
  input  logic             load,
  input  logic [WIDTH-1:0] result,
  output logic             dclk_o,
  output logic             sdata_o,
  output logic             sync_o
);

  localparam int NSYNC = 4;

  logic [NSYNC-1:0] raw_in, syn_in;
  logic rc_s, cs_s, xd_s, tag_s;
  logic rc_d, cs_d, xd_d;

  assign raw_in = {rc, cs_n, ext_dclk, tag};

  adc_sio_sync #(
    .WIDTH  (NSYNC),
    .STAGES (SYNC_STG),
    .RST_VAL(4'b1100)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (raw_in),
    .q  (syn_in)
  );

  assign {rc_s, cs_s, xd_s, tag_s} = syn_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      rc_d <= 1'b1;
      cs_d <= 1'b1;
      xd_d <= 1'b0;
    end else begin
      rc_d <= rc_s;
      cs_d <= cs_s;
      xd_d <= xd_s;
    end
  end

  logic i_start, e_trig, e_keep, x_rise, x_fall;

  assign i_start = !mode_ext && rc_d && !rc_s && !cs_s;
  assign e_trig  = mode_ext && ((!rc_d && rc_s && !cs_s) || (cs_d && !cs_s && rc_s));
  assign e_keep  = !cs_s && rc_s;
  assign x_rise  = mode_ext && xd_s && !xd_d;
  assign x_fall  = mode_ext && !xd_s && xd_d;

  // Result holding: a pending slot and the word that the next frame sends.
  logic [WIDTH-1:0] word_q, pend_q, fmt_word;
  logic             pend_vld;
  logic             i_busy, e_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q   <= '0;
      pend_q   <= '0;
      pend_vld <= 1'b0;
    end else begin
      if (pend_vld && !i_busy && !e_busy && !i_start && !e_trig) begin
        word_q   <= pend_q;
        pend_vld <= 1'b0;
      end
      if (load) begin
        pend_q   <= result;
        pend_vld <= 1'b1;
      end
    end
  end

  assign fmt_word = word_q ^ {!fmt_straight, {(WIDTH-1){1'b0}}};

  logic i_dclk, i_sdata, e_sdata, e_sync;

  adc_sio_intclk #(
    .WIDTH   (WIDTH),
    .HALF_CYC(HALF_CYC),
    .LEAD_CYC(LEAD_CYC)
  ) u_int (
    .clk    (clk),
    .rst    (rst),
    .start  (i_start),
    .word   (fmt_word),
    .tag_lvl(tag_s),
    .dclk   (i_dclk),
    .sdata  (i_sdata),
    .busy   (i_busy)
  );

  adc_sio_extclk #(
    .WIDTH(WIDTH)
  ) u_ext (
    .clk    (clk),
    .rst    (rst),
    .trig   (e_trig),
    .keep   (e_keep),
    .rise   (x_rise),
    .fall   (x_fall),
    .tag_bit(tag_s),
    .word   (fmt_word),
    .sdata  (e_sdata),
    .sync   (e_sync),
    .busy   (e_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dclk_o  <= 1'b0;
      sdata_o <= 1'b0;
      sync_o  <= 1'b0;
    end else begin
      dclk_o  <= !mode_ext && i_dclk;
      sdata_o <= mode_ext ? e_sdata : i_sdata;
      sync_o  <= mode_ext && e_sync;
    end
  end

endmodule

// File: rtl/adc_sio_port_chk.sv
module adc_sio_port_chk #(
  parameter int WIDTH = 16
) (
  input logic clk,
  input logic rst,
  input logic mode_ext,
  input logic rc,
  input logic cs_n,
  input logic dclk_o,
  input logic sdata_o,
  input logic sync_o
);

  logic       rc_q, dclk_q;
  logic [5:0] rise_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rc_q     <= 1'b1;
      dclk_q   <= 1'b0;
      rise_cnt <= '0;
    end else begin
      rc_q   <= rc;
      dclk_q <= dclk_o;
      if (rc_q && !rc)                              rise_cnt <= '0;
      else if (dclk_o && !dclk_q && rise_cnt != '1) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dclk_o && !sdata_o && !sync_o));

  // R2
  pulse_limit_chk: assert property (@(posedge clk) disable iff (rst)
    rise_cnt <= 6'(WIDTH));

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dclk_o && $past(dclk_o)) |-> $stable(sdata_o));

  // R6
  sync_mode_chk: assert property (@(posedge clk) disable iff (rst)
    sync_o |-> $past(mode_ext));

  // R8
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_ext && $past(mode_ext) && cs_n && $past(cs_n) && $past(cs_n, 2) &&
     $past(cs_n, 3) && $past(cs_n, 4) && $past(cs_n, 5)) |-> (!sdata_o && !sync_o));

endmodule

bind adc_sio_port adc_sio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mode_ext(mode_ext),
  .rc      (rc),
  .cs_n    (cs_n),
  .dclk_o  (dclk_o),
  .sdata_o (sdata_o),
  .sync_o  (sync_o)
);

// File: tb/adc_sio_port_test.sv
module adc_sio_port_test;

  localparam int CLK_NS = 10;
  localparam int W      = 16;
  localparam int HALF   = 3;
  localparam int LEAD   = 4;

  logic clk = 1'b0;
  logic rst, mode_ext, fmt_straight, rc, cs_n, ext_dclk, tag, load;
  logic [W-1:0] result;
  logic dclk_o, sdata_o, sync_o;

  adc_sio_port #(
    .WIDTH   (W),
    .HALF_CYC(HALF),
    .LEAD_CYC(LEAD)
  ) uut (
    .clk         (clk),
    .rst         (rst),
    .mode_ext    (mode_ext),
    .fmt_straight(fmt_straight),
    .rc          (rc),
    .cs_n        (cs_n),
    .ext_dclk    (ext_dclk),
    .tag         (tag),
    .load        (load),
    .result      (result),
    .dclk_o      (dclk_o),
    .sdata_o     (sdata_o),
    .sync_o      (sync_o)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] fmtw(input logic [W-1:0] v, input logic f);
    return f ? v : (v ^ 16'h8000);
  endfunction

  // Scoreboard: expected bits for self-clocked frames.
  bit expq[$];
  int frame_pulses = 0;
  int cyc = 0;
  int last_rise = 0;
  logic dprev = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!rst && dclk_o && !dprev) begin
      if (expq.size() == 0) begin
        chk("R2", 32'd1, 32'd0, "unexpected dclk_o pulse");
      end else begin
        bit b;
        b = expq.pop_front();
        chk("R3", {31'd0, sdata_o}, {31'd0, b}, "data bit at dclk_o rise");
        if (frame_pulses > 0) chk("R10", cyc - last_rise, 2*HALF, "pulse period");
      end
      frame_pulses++;
      last_rise = cyc;
    end
    dprev = dclk_o;
  end

  task automatic drive_load(input logic [W-1:0] v);
    @(negedge clk); result = v; load = 1'b1;
    @(negedge clk); load = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic int_frame(input logic [W-1:0] expw, input logic tg,
                           input logic with_load, input logic [W-1:0] lv);
    for (int i = W-1; i >= 0; i--) expq.push_back(expw[i]);
    frame_pulses = 0;
    @(negedge clk); tag = tg; rc = 1'b0;            // N0
    @(negedge clk);                                 // N1
    @(negedge clk);                                 // N2: start seen at next edge
    if (with_load) begin result = lv; load = 1'b1; end
    @(negedge clk); load = 1'b0;                    // N3
    repeat (2) @(negedge clk);
    rc = 1'b1; tag = ~tg;                           // R4: later tag change ignored
    repeat (LEAD + 2*HALF*W + 20) @(negedge clk);
    chk("R2", frame_pulses, W, "pulse count per frame");
    chk("R2", expq.size(), 0, "bits left in scoreboard");
    chk("R2", {31'd0, dclk_o}, 32'd0, "dclk_o low after frame");
    chk("R4", {31'd0, sdata_o}, {31'd0, tg}, "idle data level");
  endtask

  task automatic ext_frame(input logic [W-1:0] v, input logic f, input bit kind,
                           input logic [15:0] seed);
    logic [W-1:0] ew;
    logic tv [1:20];
    ew = fmtw(v, f);
    fmt_straight = f;
    drive_load(v);
    if (!kind) begin
      @(negedge clk); rc = 1'b0; repeat (4) @(negedge clk);
      cs_n = 1'b0; repeat (4) @(negedge clk);
      rc = 1'b1;                                    // R6 rising rc trigger
    end else begin
      @(negedge clk); rc = 1'b1; cs_n = 1'b1; repeat (4) @(negedge clk);
      cs_n = 1'b0;                                  // R6 falling cs_n trigger
    end
    repeat (2) @(negedge clk);
    for (int n = 1; n <= 20; n++) begin
      tv[n] = seed[n % 16];
      tag = tv[n];
      repeat (7) @(negedge clk);
      if (n >= 2 && n <= 17)
        chk("R7", {31'd0, sdata_o}, {31'd0, ew[17-n]}, "host-clocked data bit");
      else if (n >= 18)
        chk("R8", {31'd0, sdata_o}, {31'd0, tv[n-16]}, "delayed tag bit");
      @(negedge clk); ext_dclk = 1'b1;
      repeat (6) @(negedge clk);
      chk("R6", {31'd0, sync_o}, {31'd0, (n == 1)}, "sync during high phase");
      if (n == 3) chk("R11", {31'd0, dclk_o}, 32'd0, "no generated clock in host mode");
      repeat (2) @(negedge clk); ext_dclk = 1'b0;
    end
    @(negedge clk); cs_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R8", {31'd0, sdata_o}, 32'd0, "data low after deselect");
    ext_dclk = 1'b1; repeat (8) @(negedge clk);
    chk("R8", {31'd0, sync_o}, 32'd0, "sync low after deselect");
    ext_dclk = 1'b0; repeat (8) @(negedge clk);
    chk("R8", {31'd0, sdata_o}, 32'd0, "data stays low after deselect");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; mode_ext = 1'b0; fmt_straight = 1'b1; rc = 1'b1; cs_n = 1'b1;
    ext_dclk = 1'b0; tag = 1'b0; load = 1'b0; result = '0;
    repeat (5) @(negedge clk);
    chk("R1", {29'd0, dclk_o, sdata_o, sync_o}, 32'd0, "outputs during reset");
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {29'd0, dclk_o, sdata_o, sync_o}, 32'd0, "outputs after reset");
    cs_n = 1'b0;
    repeat (3) @(negedge clk);

    // straight binary
    drive_load(16'h1234);
    int_frame(16'h1234, 1'b1, 1'b0, '0);
    // R5 two's complement midscale and low code
    fmt_straight = 1'b0;
    drive_load(16'h8000);
    int_frame(16'h0000, 1'b0, 1'b0, '0);
    drive_load(16'h0001);
    int_frame(16'h8001, 1'b1, 1'b0, '0);
    fmt_straight = 1'b1;
    drive_load(16'hFFFF);
    int_frame(16'hFFFF, 1'b0, 1'b0, '0);

    // R9: load in the same cycle as the start
    drive_load(16'hAAAA);
    int_frame(16'hAAAA, 1'b1, 1'b1, 16'h5555);
    int_frame(16'h5555, 1'b0, 1'b0, '0);

    // R9: load in the middle of a frame
    drive_load(16'h0F0F);
    fork
      int_frame(16'h0F0F, 1'b1, 1'b0, '0);
      begin
        repeat (40) @(negedge clk);
        result = 16'hC3C3; load = 1'b1;
        @(negedge clk); load = 1'b0;
      end
    join
    int_frame(16'hC3C3, 1'b0, 1'b0, '0);

    // R11: rc falls while deselected, host clock toggles in self-clocked mode
    cs_n = 1'b1;
    frame_pulses = 0;
    repeat (3) @(negedge clk);
    rc = 1'b0; repeat (10) @(negedge clk); rc = 1'b1;
    for (int k = 0; k < 4; k++) begin
      ext_dclk = 1'b1; repeat (6) @(negedge clk);
      chk("R11", {31'd0, sync_o}, 32'd0, "no sync in self-clocked mode");
      ext_dclk = 1'b0; repeat (6) @(negedge clk);
    end
    repeat (LEAD + 2*HALF*W) @(negedge clk);
    chk("R11", frame_pulses, 0, "no pulses while deselected");

    // host-clocked readout
    mode_ext = 1'b1;
    repeat (5) @(negedge clk);
    ext_frame(16'hA5C3, 1'b1, 1'b0, 16'hB38E);
    ext_frame(16'h7FFF, 1'b0, 1'b1, 16'h4C6D);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule